// File: doc/BRIEF.md
# Interleaved Node Range Decoder

This block takes a 48-bit physical system address and finds which memory node owns it. It checks the address against a bank of programmable address windows. Each window has an enable pair, a base, a limit and an optional node-interleave qualifier. The lowest-numbered window that accepts the address wins. Its node number is reported, together with the number of address bits that node interleaving consumes in that window.

The block can also remap one swapped region in the low 16 GiB of the address space. If that remap is enabled and the address falls into the programmed window, a 7-bit region index is XORed into the address at 128 MiB granularity. The adjusted address is then handed downstream.

The decode is combinational. The results are captured in output registers one cycle after a request strobe. A request that no window accepts raises a miss flag and returns all other results as zero. The window registers are plain inputs, and this block does not program them.

Top module: `node_range_decoder`

## Requirements
- R1: A window takes part in the search when at least one of its two enable bits (`rng_enable[i]`, values 2'b01, 2'b10 or 2'b11) is set. With 2'b00 it never matches.
- R2: The window bounds are inclusive. The low bound is {base_hi, base_field, 24'h000000}. The high bound is {limit_hi, limit_field, 24'hFFFFFF}. An address equal to either bound matches, and one step outside does not.
- R3: When a window's 3-bit interleave mask is nonzero, the window matches only if its 3-bit interleave select equals address bits [14:12] ANDed with the mask. A mask of zero removes this qualification.
- R4: The interleave bit count `out_ilog` is 0, 1, 2 or 3 for a winning mask of 3'b000, 3'b001, 3'b011 or 3'b111 respectively.
- R5: When several windows match, the one with the lowest index wins, and `out_node` is that window's 3-bit node field.
- R6: The region remap applies only when `swap_en` is 1, address bits [47:34] are all zero, and the 7-bit index `addr[33:27]` either lies in [swap_base, swap_limit] inclusive or is below `swap_size`.
- R7: When the remap applies, `out_addr` equals the input address with `swap_base` XORed into bits [33:27]. Otherwise `out_addr` equals the input address. Bits outside [33:27] are never altered.
- R8: A request that matches no window gives `out_miss`=1, and `out_node`, `out_ilog`, `out_addr` and `out_mask_err` are all 0.
- R9: A winning mask outside {000, 001, 011, 111} sets `out_mask_err`=1 and reports `out_ilog`=0. The node and address are still reported.
- R10: All outputs are registered. `out_valid` is `req_valid` delayed by one clock. In a cycle after no request, all outputs are 0, and reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 48 | System address to decode |
| rng_enable | input | NUM_RANGES x 2 | Per-window enable pair |
| rng_base | input | NUM_RANGES x 16 | Low bound, address bits 39:24 |
| rng_base_hi | input | NUM_RANGES x 8 | Low bound, address bits 47:40 |
| rng_limit | input | NUM_RANGES x 16 | High bound, address bits 39:24 |
| rng_limit_hi | input | NUM_RANGES x 8 | High bound, address bits 47:40 |
| rng_il_mask | input | NUM_RANGES x 3 | Node-interleave mask |
| rng_il_sel | input | NUM_RANGES x 3 | Node-interleave select |
| rng_node | input | NUM_RANGES x 3 | Owning node of the window |
| swap_en | input | 1 | Region remap enable |
| swap_base | input | 7 | Remap window start, 128 MiB units |
| swap_limit | input | 7 | Remap window end, 128 MiB units |
| swap_size | input | 7 | Remap low-region size, 128 MiB units |
| out_valid | output | 1 | Result valid |
| out_node | output | 3 | Owning node |
| out_ilog | output | 2 | Interleave bit count |
| out_addr | output | 48 | Address after optional remap |
| out_miss | output | 1 | No window matched |
| out_mask_err | output | 1 | Winning mask is not a legal value |

## Verification
The only state is the output register stage, so any fault in the decode shows up in the cycle right after the request. A bad priority or bounds decision shows as the wrong node, or as a spurious or missing miss flag. A bad remap decision shows as changed address bits inside [33:27], or as changed bits outside that field. A stale or leaked register value shows as nonzero results on a miss or on an idle cycle. The reference model recomputes every output for every request, so a divergence is reported one clock after it is caused.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  localparam int ADDR_W    = 48;
  localparam int FIELD_LSB = 24;
  localparam int FIELD_W   = 16;
  localparam int HI_W      = ADDR_W - FIELD_LSB - FIELD_W;
  localparam int MASK_W    = 3;
  localparam int NODE_W    = 3;
  localparam int ILOG_W    = 2;
  localparam int IL_LSB    = 12;
  localparam int SWAP_LSB  = 27;
  localparam int SWAP_W    = 7;
  localparam int SWAP_TOP  = SWAP_LSB + SWAP_W;

  typedef struct packed {
    logic [ILOG_W-1:0] bits;
    logic              bad;
  } ilog_t;

  // Legal masks are contiguous low ones; the count of ones is the bit count.
  function automatic ilog_t decode_mask(input logic [MASK_W-1:0] m);
    ilog_t r;
    r.bad  = 1'b0;
    r.bits = '0;
    case (m)
      3'b000: r.bits = 2'd0;
      3'b001: r.bits = 2'd1;
      3'b011: r.bits = 2'd2;
      3'b111: r.bits = 2'd3;
      default: r.bad = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] make_low(input logic [HI_W-1:0] hi,
                                                 input logic [FIELD_W-1:0] f);
    return {hi, f, {FIELD_LSB{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] make_high(input logic [HI_W-1:0] hi,
                                                  input logic [FIELD_W-1:0] f);
    return {hi, f, {FIELD_LSB{1'b1}}};
  endfunction

  function automatic logic in_swap_window(input logic [ADDR_W-1:0] a,
                                          input logic [SWAP_W-1:0] b,
                                          input logic [SWAP_W-1:0] l,
                                          input logic [SWAP_W-1:0] s);
    logic [SWAP_W-1:0] idx;
    idx = a[SWAP_TOP-1:SWAP_LSB];
    if (|a[ADDR_W-1:SWAP_TOP]) return 1'b0;
    return ((idx >= b) && (idx <= l)) || (idx < s);
  endfunction
endpackage

// File: rtl/nrd_range_match.sv
module nrd_range_match
  import nrd_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         enable,
  input  logic [FIELD_W-1:0] base_f,
  input  logic [HI_W-1:0]    base_hi,
  input  logic [FIELD_W-1:0] lim_f,
  input  logic [HI_W-1:0]    lim_hi,
  input  logic [MASK_W-1:0]  il_mask,
  input  logic [MASK_W-1:0]  il_sel,
  output logic               hit
);
  logic [ADDR_W-1:0] lo_bound;
  logic [ADDR_W-1:0] hi_bound;
  logic              in_bounds;
  logic              sel_ok;
  logic              enabled;

  assign lo_bound  = make_low(base_hi, base_f);
  assign hi_bound  = make_high(lim_hi, lim_f);
  assign enabled   = |enable;
  assign in_bounds = (addr >= lo_bound) && (addr <= hi_bound);
  assign sel_ok    = (il_mask == '0) ||
                     (il_sel == (addr[IL_LSB +: MASK_W] & il_mask));
  assign hit       = enabled && in_bounds && sel_ok;
endmodule

// File: rtl/nrd_first_hit.sv
module nrd_first_hit #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/nrd_region_swap.sv
module nrd_region_swap
  import nrd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              en,
  input  logic [SWAP_W-1:0] base,
  input  logic [SWAP_W-1:0] limit,
  input  logic [SWAP_W-1:0] size,
  output logic [ADDR_W-1:0] addr_out
);
  logic              take;
  logic [ADDR_W-1:0] flip;

  assign take     = en && in_swap_window(addr_in, base, limit, size);
  assign flip     = {{(ADDR_W-SWAP_TOP){1'b0}}, (take ? base : {SWAP_W{1'b0}}),
                     {SWAP_LSB{1'b0}}};
  assign addr_out = addr_in ^ flip;
endmodule

// File: rtl/node_range_decoder.sv
module node_range_decoder
  import nrd_pkg::*;
#(
  parameter int NUM_RANGES = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [NUM_RANGES-1:0][1:0]          rng_enable,
  input  logic [NUM_RANGES-1:0][FIELD_W-1:0]  rng_base,
  input  logic [NUM_RANGES-1:0][HI_W-1:0]     rng_base_hi,
  input  logic [NUM_RANGES-1:0][FIELD_W-1:0]  rng_limit,
  input  logic [NUM_RANGES-1:0][HI_W-1:0]     rng_limit_hi,
  input  logic [NUM_RANGES-1:0][MASK_W-1:0]   rng_il_mask,
  input  logic [NUM_RANGES-1:0][MASK_W-1:0]   rng_il_sel,
  input  logic [NUM_RANGES-1:0][NODE_W-1:0]   rng_node,
  input  logic                                swap_en,
  input  logic [SWAP_W-1:0]                   swap_base,
  input  logic [SWAP_W-1:0]                   swap_limit,
  input  logic [SWAP_W-1:0]                   swap_size,
  output logic                                out_valid,
  output logic [NODE_W-1:0]                   out_node,
  output logic [ILOG_W-1:0]                   out_ilog,
  output logic [ADDR_W-1:0]                   out_addr,
  output logic                                out_miss,
  output logic                                out_mask_err
);
  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

  logic [NUM_RANGES-1:0] match_vec;
  logic                  any_hit;
  logic [IDX_W-1:0]      win_idx;
  ilog_t                 win_ilog;
  logic [NODE_W-1:0]     win_node;
  logic [ADDR_W-1:0]     swapped_addr;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
    nrd_range_match u_match (
      .addr    (req_addr),
      .enable  (rng_enable[g]),
      .base_f  (rng_base[g]),
      .base_hi (rng_base_hi[g]),
      .lim_f   (rng_limit[g]),
      .lim_hi  (rng_limit_hi[g]),
      .il_mask (rng_il_mask[g]),
      .il_sel  (rng_il_sel[g]),
      .hit     (match_vec[g])
    );
  end

  nrd_first_hit #(.N(NUM_RANGES), .IDX_W(IDX_W)) u_pick (
    .vec (match_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  assign win_ilog = decode_mask(rng_il_mask[win_idx]);
  assign win_node = rng_node[win_idx];

  nrd_region_swap u_swap (
    .addr_in  (req_addr),
    .en       (swap_en),
    .base     (swap_base),
    .limit    (swap_limit),
    .size     (swap_size),
    .addr_out (swapped_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_node     <= '0;
      out_ilog     <= '0;
      out_addr     <= '0;
      out_miss     <= 1'b0;
      out_mask_err <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid && any_hit) begin
        out_node     <= win_node;
        out_ilog     <= win_ilog.bits;
        out_mask_err <= win_ilog.bad;
        out_addr     <= swapped_addr;
        out_miss     <= 1'b0;
      end else begin
        out_node     <= '0;
        out_ilog     <= '0;
        out_mask_err <= 1'b0;
        out_addr     <= '0;
        out_miss     <= req_valid;
      end
    end
  end
endmodule

// File: rtl/nrd_checker.sv
module nrd_checker
  import nrd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              swap_en,
  input logic              any_hit,
  input logic              out_valid,
  input logic [NODE_W-1:0] out_node,
  input logic [ILOG_W-1:0] out_ilog,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_miss,
  input logic              out_mask_err
);
  localparam logic [ADDR_W-1:0] SWAP_FIELD =
    {{(ADDR_W-SWAP_TOP){1'b0}}, {SWAP_W{1'b1}}, {SWAP_LSB{1'b0}}};

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_miss && out_addr == '0));
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (out_valid && out_node == '0 && out_ilog == '0 &&
                  out_addr == '0 && !out_mask_err));
  p_miss_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_miss == !$past(any_hit)));
  p_err_ilog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_mask_err |-> (out_ilog == '0 && !out_miss && out_valid));
  p_field_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && any_hit |=> (((out_addr ^ $past(req_addr)) & ~SWAP_FIELD) == '0));
  p_swap_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && any_hit && !swap_en |=> (out_addr == $past(req_addr)));
  p_swap_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && any_hit && (|req_addr[ADDR_W-1:SWAP_TOP]) |=>
      (out_addr == $past(req_addr)));
endmodule

bind node_range_decoder nrd_checker u_nrd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .swap_en      (swap_en),
  .any_hit      (any_hit),
  .out_valid    (out_valid),
  .out_node     (out_node),
  .out_ilog     (out_ilog),
  .out_addr     (out_addr),
  .out_miss     (out_miss),
  .out_mask_err (out_mask_err)
);

// File: tb/tb_node_range_decoder.sv
module tb_node_range_decoder;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [47:0] req_addr = '0;
  logic [NR-1:0][1:0]  rng_enable;
  logic [NR-1:0][15:0] rng_base, rng_limit;
  logic [NR-1:0][7:0]  rng_base_hi, rng_limit_hi;
  logic [NR-1:0][2:0]  rng_il_mask, rng_il_sel, rng_node;
  logic swap_en;
  logic [6:0] swap_base, swap_limit, swap_size;
  logic out_valid, out_miss, out_mask_err;
  logic [2:0] out_node;
  logic [1:0] out_ilog;
  logic [47:0] out_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  node_range_decoder #(.NUM_RANGES(NR)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rng_enable(rng_enable), .rng_base(rng_base), .rng_base_hi(rng_base_hi),
    .rng_limit(rng_limit), .rng_limit_hi(rng_limit_hi),
    .rng_il_mask(rng_il_mask), .rng_il_sel(rng_il_sel), .rng_node(rng_node),
    .swap_en(swap_en), .swap_base(swap_base), .swap_limit(swap_limit),
    .swap_size(swap_size), .out_valid(out_valid), .out_node(out_node),
    .out_ilog(out_ilog), .out_addr(out_addr), .out_miss(out_miss),
    .out_mask_err(out_mask_err));

  // expected results
  bit e_valid, e_miss, e_err;
  int e_node, e_ilog;
  longint unsigned e_addr;

  task automatic model(input bit v, input longint unsigned a);
    bit found = 0;
    e_valid = v; e_miss = 0; e_err = 0; e_node = 0; e_ilog = 0; e_addr = 0;
    if (!v) return;
    for (int r = 0; r < NR; r++) begin
      longint unsigned lo, hi;
      int m, s;
      lo = (longint'(rng_base_hi[r]) << 40) + longint'(rng_base[r]) * 64'd16777216;
      hi = (longint'(rng_limit_hi[r]) << 40) + (longint'(rng_limit[r]) + 1) * 64'd16777216 - 1;
      m = rng_il_mask[r];
      s = rng_il_sel[r];
      if (!found && rng_enable[r] != 0 && a >= lo && a <= hi &&
          (m == 0 || s == (int'((a >> 12) % 8) & m))) begin
        found = 1;
        e_node = rng_node[r];
        if (m == 0) e_ilog = 0;
        else if (m == 1) e_ilog = 1;
        else if (m == 3) e_ilog = 2;
        else if (m == 7) e_ilog = 3;
        else e_err = 1;
      end
    end
    if (!found) begin
      e_miss = 1;
      return;
    end
    e_addr = a;
    if (swap_en && (a >> 34) == 0) begin
      longint unsigned idx;
      idx = a >> 27;
      if ((idx >= swap_base && idx <= swap_limit) || idx < swap_size)
        e_addr = a ^ (longint'(swap_base) << 27);
    end
  endtask

  task automatic check(input string tag);
    total++;
    if (out_valid !== e_valid || out_miss !== e_miss || out_mask_err !== e_err ||
        out_node !== 3'(e_node) || out_ilog !== 2'(e_ilog) || out_addr !== 48'(e_addr)) begin
      bad++;
      $display("FAIL %s: got v=%0b miss=%0b err=%0b node=%0d ilog=%0d addr=%h exp v=%0b miss=%0b err=%0b node=%0d ilog=%0d addr=%h",
               tag, out_valid, out_miss, out_mask_err, out_node, out_ilog, out_addr,
               e_valid, e_miss, e_err, e_node, e_ilog, 48'(e_addr));
    end
  endtask

  task automatic send(input longint unsigned a, input bit v, input string tag);
    @(negedge clk);
    req_addr = 48'(a);
    req_valid = v;
    model(v, a);
    @(posedge clk);
    #2;
    check(tag);
  endtask

  task automatic clear_cfg();
    rng_enable = '0; rng_base = '0; rng_limit = '0; rng_base_hi = '0;
    rng_limit_hi = '0; rng_il_mask = '0; rng_il_sel = '0; rng_node = '0;
    swap_en = 0; swap_base = 0; swap_limit = 0; swap_size = 0;
  endtask

  task automatic set_rng(input int r, input logic [1:0] en, input logic [15:0] b,
                         input logic [15:0] l, input logic [2:0] m,
                         input logic [2:0] s, input logic [2:0] n);
    rng_enable[r] = en; rng_base[r] = b; rng_limit[r] = l; rng_base_hi[r] = 0;
    rng_limit_hi[r] = 0; rng_il_mask[r] = m; rng_il_sel[r] = s; rng_node[r] = n;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    repeat (3) @(posedge clk);
    #2;
    model(0, 0);
    check("R10 reset");
    @(negedge clk);
    rst_n = 1;

    // R1 / R2: single window 0x1000_0000 .. 0x1FFF_FFFF
    set_rng(0, 2'b01, 16'h0010, 16'h001F, 0, 0, 3'd5);
    send(64'h1000_0000, 1, "R2 low bound");
    send(64'h1FFF_FFFF, 1, "R2 high bound");
    send(64'h2000_0000, 1, "R2 above high bound");
    send(64'h0FFF_FFFF, 1, "R2 below low bound");
    send(64'h1800_0000, 1, "R1 enable 01");
    rng_enable[0] = 2'b10;
    send(64'h1800_0000, 1, "R1 enable 10");
    rng_enable[0] = 2'b00;
    send(64'h1800_0000, 1, "R1 R8 disabled miss");
    send(64'h1800_0000, 0, "R10 idle");

    // R3 / R4: interleave
    set_rng(0, 2'b11, 16'h0010, 16'h001F, 3'b001, 3'd1, 3'd2);
    set_rng(1, 2'b11, 16'h0010, 16'h001F, 3'b001, 3'd0, 3'd3);
    send(64'h1000_1000, 1, "R3 sel bit12=1");
    send(64'h1000_0000, 1, "R3 sel bit12=0");
    set_rng(0, 2'b11, 16'h0010, 16'h001F, 3'b011, 3'd2, 3'd4);
    rng_enable[1] = 0;
    send(64'h1000_2000, 1, "R4 mask 011");
    send(64'h1000_3000, 1, "R3 mask 011 mismatch");
    set_rng(0, 2'b11, 16'h0010, 16'h001F, 3'b111, 3'd5, 3'd7);
    send(64'h1000_5000, 1, "R4 mask 111");
    send(64'h1000_4000, 1, "R3 mask 111 mismatch");

    // R5: priority
    clear_cfg();
    set_rng(5, 2'b01, 16'h0000, 16'h00FF, 0, 0, 3'd1);
    set_rng(2, 2'b01, 16'h0010, 16'h001F, 0, 0, 3'd6);
    send(64'h1234_5678, 1, "R5 overlap lowest wins");
    send(64'h4000_0000, 1, "R5 only upper window");

    // R9: illegal masks
    set_rng(2, 2'b01, 16'h0010, 16'h001F, 3'b101, 3'd0, 3'd6);
    send(64'h1000_0000, 1, "R9 mask 101");
    rng_il_mask[2] = 3'b010;
    send(64'h1000_0000, 1, "R9 mask 010");
    rng_il_mask[2] = 3'b000;

    // R6 / R7: region remap
    clear_cfg();
    set_rng(0, 2'b01, 16'h0000, 16'h03FF, 0, 0, 3'd1);
    set_rng(1, 2'b01, 16'h0400, 16'h07FF, 0, 0, 3'd2);
    swap_en = 1; swap_base = 7'd2; swap_limit = 7'd3; swap_size = 7'd2;
    send(64'h0000_1234, 1, "R7 low index swapped");
    send(64'h1800_00AB, 1, "R7 window index swapped");
    send(64'h2800_0000, 1, "R6 outside window");
    send(64'h4_0000_0000, 1, "R6 high bits set");
    swap_en = 0;
    send(64'h0000_1234, 1, "R6 disabled");

    // mixed random sweep
    clear_cfg();
    set_rng(0, 2'b01, 16'h0000, 16'h007F, 3'b001, 3'd1, 3'd0);
    set_rng(1, 2'b10, 16'h0000, 16'h007F, 3'b001, 3'd0, 3'd1);
    set_rng(3, 2'b11, 16'h0080, 16'h01FF, 3'b011, 3'd3, 3'd3);
    set_rng(4, 2'b01, 16'h0080, 16'h01FF, 3'b000, 3'd0, 3'd4);
    set_rng(6, 2'b01, 16'h0300, 16'h07FF, 3'b110, 3'd2, 3'd6);
    swap_en = 1; swap_base = 7'd5; swap_limit = 7'd9; swap_size = 7'd3;
    for (int i = 0; i < 400; i++) begin
      longint unsigned a;
      a = {$urandom, $urandom} & 64'h7_FFFF_FFFF;
      send(a, ($urandom % 5) != 0, "R5 R6 R7 random sweep");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule